// File: doc/BRIEF.md
# Event-Driven PI Frequency Controller for Thermal Limiting

This block computes a normalised clock-frequency command for one processor core, and it runs only when a thermal event arrives. Each event brings two temperature samples: the one that triggered the event and the one taken one sensor period earlier. It also brings two controller gains, the highest admissible temperature and a guard margin. On every accepted event the block derives a set point from the temperature limit and the margin. It then brings its integrator into line with the command that was held since the previous event, and evaluates a proportional-integral law. A single multiplier is shared across the steps, and a four-step sequencer controls it.

The PI result is bounded to the range of available frequencies. It is then compared with the request of the load-driven governor, and the lower of the two is applied. The applied value is also what the next pre-update starts from, so the integrator follows what the core actually ran at. Between events the command does not move. All quantities are two's-complement fixed point with eight fraction bits, so 1.0 is encoded as 0x0100.

Top module: `evpi_thermal_ctrl`

## Requirements
- R1: While reset is high and after it is released, the frequency output is 0x0100 (full speed) and done is low. The stored previous command also starts at 0x0100.
- R2: The set point is taken at each accepted event as limit minus twice the margin. It is not the limit minus the margin, and it is not sampled between events.
- R3: Before the new command is formed, the integrator is set to x = u_prev + round((gi − gp)·(w_prev − y_prev)). Here y_prev is the earlier sample of the event and w_prev is the set point of the previous event. On the first event after reset, w_prev is the set point of that same event.
- R4: The PI command is u = x + round(gp·(w − y_now)). Each product is rounded by adding 2^(F−1) (0x80) and then shifting right arithmetically by F = 8 bits.
- R5: The PI command is saturated to 0x0000..0x0100 before it is used.
- R6: The governor request is sampled at the event, clamped to 0x0000..0x0100 and treated as signed Q8.8. The applied frequency is the lower of that value and the saturated PI command.
- R7: The previous command u_prev used by the next pre-update is the applied frequency, including when the governor limited it.
- R8: done is high for exactly one cycle, four clock edges after the edge that accepted the event. freq_o carries the new value in that same cycle.
- R9: freq_o changes only in a cycle in which done is high. Input changes between events have no effect on it.
- R10: An event strobe seen while a computation is in progress is ignored. A strobe in the cycle in which done is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 1 | Event strobe, one cycle per event |
| temp_now_i | input | DW | Temperature sample at the event, signed Q8.8 |
| temp_prev_i | input | DW | Sample one sensor period before the event, signed Q8.8 |
| gain_int_i | input | DW | Integral-path gain gi, signed Q8.8 |
| gain_prop_i | input | DW | Proportional gain gp, signed Q8.8 |
| temp_max_i | input | DW | Highest admissible temperature, signed Q8.8 |
| margin_i | input | DW | Guard margin, signed Q8.8 |
| gov_req_i | input | DW | Governor frequency request, signed Q8.8 |
| freq_o | output | DW | Applied frequency command, 0x0000..0x0100 |
| done_o | output | 1 | One-cycle pulse when freq_o has been updated |

## Verification
The critical overlap is a new event strobe arriving in the very cycle that the previous result is published on done. In that cycle the block must accept the new event and start from the freshly applied command and set point. Strobes in the three busy cycles before it must be discarded. The bench provokes this by holding the strobe high with changing data across a whole computation and then striking again on the done cycle. It judges the outcome by counting exactly two done pulses and by comparing each published value with a behavioural model evaluated on every clock.

// File: rtl/evpi_pkg.sv
package evpi_pkg;

  // Sequencer steps: wait, integrator pre-update, proportional step, publish
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_PROP  = 2'd2,
    ST_APPLY = 2'd3
  } evpi_state_e;

endpackage

// File: rtl/evpi_seq.sv
module evpi_seq
  import evpi_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        evt_i,
  output evpi_state_e state_o,
  output logic        accept_o
);

  evpi_state_e state_q, state_d;

  assign accept_o = (state_q == ST_IDLE) && evt_i;
  assign state_o  = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (evt_i) state_d = ST_PRE;
      ST_PRE:   state_d = ST_PROP;
      ST_PROP:  state_d = ST_APPLY;
      ST_APPLY: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  // R10: a strobe while busy never restarts the pre-update step
  a_r10_no_restart: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> (state_q != ST_PRE));

  // R8: once started, the computation walks forward without stalling
  a_r8_walk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PRE) |=> (state_q == ST_PROP));

endmodule

// File: rtl/evpi_mul_rnd.sv
module evpi_mul_rnd #(
  parameter int AW = 17,
  parameter int BW = 19,
  parameter int FW = 8,
  localparam int RW = AW + BW + 1 - FW
) (
  input  logic signed [AW-1:0] a_i,
  input  logic signed [BW-1:0] b_i,
  output logic signed [RW-1:0] p_o
);

  logic signed [AW+BW-1:0] full;
  assign full = a_i * b_i;

  generate
    if (FW > 0) begin : g_round
      localparam logic signed [AW+BW:0] HALF = (AW+BW+1)'(64'd1 << (FW-1));
      logic signed [AW+BW:0] sum;
      assign sum = (AW+BW+1)'(full) + HALF;
      assign p_o = RW'(sum >>> FW);
    end else begin : g_exact
      assign p_o = RW'(full);
    end
  endgenerate

endmodule

// File: rtl/evpi_sat.sv
module evpi_sat #(
  parameter int IW = 31,
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic signed [IW-1:0] v_i,
  output logic        [DW-1:0] y_o
);

  localparam logic signed [IW-1:0] ONE_W = IW'(64'd1 << FW);
  localparam logic        [DW-1:0] ONE_D = DW'(64'd1 << FW);

  always_comb begin
    if (v_i < 0)          y_o = '0;
    else if (v_i > ONE_W) y_o = ONE_D;
    else                  y_o = v_i[DW-1:0];
  end

endmodule

// File: rtl/evpi_core.sv
module evpi_core
  import evpi_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  evpi_state_e          state_i,
  input  logic                 accept_i,
  input  logic signed [DW-1:0] temp_now_i,
  input  logic signed [DW-1:0] temp_prev_i,
  input  logic signed [DW-1:0] gain_int_i,
  input  logic signed [DW-1:0] gain_prop_i,
  input  logic signed [DW-1:0] temp_max_i,
  input  logic signed [DW-1:0] margin_i,
  input  logic signed [DW-1:0] gov_req_i,
  output logic        [DW-1:0] freq_o,
  output logic                 done_o
);

  localparam int SW = DW + 2;              // set point width
  localparam int EW = DW + 3;              // error width
  localparam int GW = DW + 1;              // gain difference width
  localparam int RW = GW + EW + 1 - FW;    // rounded product width
  localparam int AW = RW + 2;              // accumulator width
  localparam logic [DW-1:0] ONE = DW'(64'd1 << FW);

  // Operands captured at the event
  logic signed [SW-1:0] w_new_q, w_old_q;
  logic signed [DW-1:0] y_now_q, y_prev_q, gp_q;
  logic signed [GW-1:0] gdiff_q;
  logic        [DW-1:0] gov_q;
  logic                 primed_q;

  // Result state: the applied command doubles as u(k-1)
  logic        [DW-1:0] u_q;
  logic signed [AW-1:0] acc_q;
  logic                 done_q;
  logic                 pv_q;

  logic signed [SW-1:0] w_calc, w_ref;
  logic signed [EW-1:0] e_pre, e_prop;
  logic signed [GW-1:0] mul_a;
  logic signed [EW-1:0] mul_b;
  logic signed [RW-1:0] prod;
  logic        [DW-1:0] gov_sat, pi_sat, applied;

  // R2: set point is limit minus twice the margin
  assign w_calc = SW'(temp_max_i) - (SW'(margin_i) <<< 1);

  // R3: first event after reset uses its own set point as the previous one
  assign w_ref  = primed_q ? w_old_q : w_new_q;
  assign e_pre  = EW'(w_ref) - EW'(y_prev_q);
  assign e_prop = EW'(w_new_q) - EW'(y_now_q);

  always_comb begin
    mul_a = gdiff_q;
    mul_b = e_pre;
    if (state_i == ST_PROP) begin
      mul_a = GW'(gp_q);
      mul_b = e_prop;
    end
  end

  evpi_mul_rnd #(.AW(GW), .BW(EW), .FW(FW)) u_mul (
    .a_i (mul_a),
    .b_i (mul_b),
    .p_o (prod)
  );

  evpi_sat #(.IW(DW), .DW(DW), .FW(FW)) u_sat_gov (
    .v_i (gov_req_i),
    .y_o (gov_sat)
  );

  evpi_sat #(.IW(AW), .DW(DW), .FW(FW)) u_sat_pi (
    .v_i (acc_q),
    .y_o (pi_sat)
  );

  // R6: lower of governor and PI command wins
  assign applied = (pi_sat < gov_q) ? pi_sat : gov_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_new_q  <= '0;
      w_old_q  <= '0;
      y_now_q  <= '0;
      y_prev_q <= '0;
      gp_q     <= '0;
      gdiff_q  <= '0;
      gov_q    <= '0;
      primed_q <= 1'b0;
      u_q      <= ONE;
      acc_q    <= '0;
      done_q   <= 1'b0;
      pv_q     <= 1'b0;
    end else begin
      pv_q   <= 1'b1;
      done_q <= 1'b0;
      if (accept_i) begin
        w_new_q  <= w_calc;
        y_now_q  <= temp_now_i;
        y_prev_q <= temp_prev_i;
        gp_q     <= gain_prop_i;
        gdiff_q  <= GW'(gain_int_i) - GW'(gain_prop_i);
        gov_q    <= gov_sat;
      end
      unique case (state_i)
        ST_PRE:   acc_q <= AW'($signed({1'b0, u_q})) + AW'(prod);
        ST_PROP:  acc_q <= acc_q + AW'(prod);
        ST_APPLY: begin
          u_q      <= applied;       // R7: state tracks the applied value
          w_old_q  <= w_new_q;
          primed_q <= 1'b1;
          done_q   <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign freq_o = u_q;
  assign done_o = done_q;

  a_r5_range: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (u_q <= ONE));

  a_r6_gov_cap: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (u_q <= gov_q));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (pv_q && !done_q) |-> $stable(u_q));

endmodule

// File: rtl/evpi_thermal_ctrl.sv
module evpi_thermal_ctrl
  import evpi_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          evt_i,
  input  logic [DW-1:0] temp_now_i,
  input  logic [DW-1:0] temp_prev_i,
  input  logic [DW-1:0] gain_int_i,
  input  logic [DW-1:0] gain_prop_i,
  input  logic [DW-1:0] temp_max_i,
  input  logic [DW-1:0] margin_i,
  input  logic [DW-1:0] gov_req_i,
  output logic [DW-1:0] freq_o,
  output logic          done_o
);

  evpi_state_e state;
  logic        accept;

  evpi_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt_i),
    .state_o  (state),
    .accept_o (accept)
  );

  evpi_core #(.DW(DW), .FW(FW)) u_core (
    .clk         (clk),
    .rst         (rst),
    .state_i     (state),
    .accept_i    (accept),
    .temp_now_i  ($signed(temp_now_i)),
    .temp_prev_i ($signed(temp_prev_i)),
    .gain_int_i  ($signed(gain_int_i)),
    .gain_prop_i ($signed(gain_prop_i)),
    .temp_max_i  ($signed(temp_max_i)),
    .margin_i    ($signed(margin_i)),
    .gov_req_i   ($signed(gov_req_i)),
    .freq_o      (freq_o),
    .done_o      (done_o)
  );

  a_r8_latency: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(accept, 4));

  a_r8_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

endmodule

// File: tb/evpi_thermal_ctrl_test.sv
module evpi_thermal_ctrl_test;

  localparam int DW = 16;
  localparam int FW = 8;
  localparam longint ONE = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          evt = 1'b0;
  logic [DW-1:0] yn = '0, yp = '0, gi = '0, gp = '0, tm = '0, mg = '0, gv = '0;
  logic [DW-1:0] freq;
  logic          done;

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_tag = "R1";
  bit    finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  evpi_thermal_ctrl #(.DW(DW), .FW(FW)) uut (
    .clk (clk), .rst (rst), .evt_i (evt),
    .temp_now_i (yn), .temp_prev_i (yp),
    .gain_int_i (gi), .gain_prop_i (gp),
    .temp_max_i (tm), .margin_i (mg), .gov_req_i (gv),
    .freq_o (freq), .done_o (done)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  function automatic longint sx(input logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction
  function automatic longint rnd(input longint p);
    return (p + (64'sd1 <<< (FW-1))) >>> FW;
  endfunction
  function automatic longint clampq(input longint v);
    if (v < 0) return 0;
    if (v > ONE) return ONE;
    return v;
  endfunction

  longint m_u, m_pend, m_wold, m_pw;
  int     m_cnt;
  bit     m_done, m_primed, m_valid = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      m_u = ONE; m_done = 0; m_cnt = 0; m_primed = 0; m_wold = 0; m_valid = 1;
    end else begin
      m_done = 0;
      if (m_cnt != 0) begin
        m_cnt++;
        if (m_cnt == 4) begin
          m_u = m_pend; m_wold = m_pw; m_primed = 1; m_done = 1; m_cnt = 0;
        end
      end else if (evt) begin
        longint w, wr, x, u, g;
        w  = sx(tm) - 2 * sx(mg);
        wr = m_primed ? m_wold : w;
        x  = m_u + rnd((sx(gi) - sx(gp)) * (wr - sx(yp)));
        u  = x + rnd(sx(gp) * (w - sx(yn)));
        g  = clampq(sx(gv));
        m_pend = (clampq(u) < g) ? clampq(u) : g;
        m_pw = w;
        m_cnt = 1;
      end
    end
  end

  int n_done_seen = 0;
  always @(negedge clk) begin
    if (m_valid && !finished) begin
      chk(done === m_done, {cur_tag, " done"}, longint'(done), longint'(m_done));
      chk(longint'(freq) == m_u, {cur_tag, " freq"}, longint'(freq), m_u);
    end
    if (done === 1'b1) n_done_seen++;
  end

  // ---------------- stimulus helpers ----------------
  task automatic put(input logic [DW-1:0] a_yn, a_yp, a_gi, a_gp, a_tm, a_mg, a_gv, input bit a_ev);
    yn = a_yn; yp = a_yp; gi = a_gi; gp = a_gp; tm = a_tm; mg = a_mg; gv = a_gv; evt = a_ev;
  endtask

  // Issue one event and return at the negedge where done is visible
  task automatic fire(input logic [DW-1:0] a_yn, a_yp, a_gi, a_gp, a_tm, a_mg, a_gv);
    @(negedge clk); put(a_yn, a_yp, a_gi, a_gp, a_tm, a_mg, a_gv, 1'b1);
    @(negedge clk); evt = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_result(input longint exp, input string tag);
    chk(done === 1'b1, {tag, " done pulse"}, longint'(done), 1);
    chk(longint'(freq) == exp, {tag, " value"}, longint'(freq), exp);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int d0;
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    chk(freq == 16'h0100, "R1 reset freq", longint'(freq), ONE);
    chk(done == 1'b0, "R1 reset done", longint'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(freq == 16'h0100, "R1 after release", longint'(freq), ONE);

    // First event: own set point used as previous one (R3), rounding (R4)
    cur_tag = "R3";
    fire(16'd22144, 16'd22144, 16'd128, 16'd64, 16'd23040, 16'd512, 16'd256);
    expect_result(192, "R3/R4 first event");
    @(negedge clk);
    chk(done == 1'b0, "R8 single-cycle done", longint'(done), 0);

    // Governor caps the result (R6), then applied value feeds pre-update (R7)
    cur_tag = "R6";
    fire(16'd22144, 16'd22144, 16'd128, 16'd64, 16'd23040, 16'd512, 16'd100);
    expect_result(100, "R6 governor min");
    cur_tag = "R7";
    fire(16'd22144, 16'd22144, 16'd128, 16'd64, 16'd23040, 16'd512, 16'd256);
    expect_result(36, "R7 state tracks applied");

    // Saturation at both ends (R5)
    cur_tag = "R5";
    fire(16'd5120, 16'd5120, 16'd384, 16'd256, 16'd23040, 16'd512, 16'd256);
    expect_result(256, "R5 upper clamp");
    fire(16'd30720, 16'd30720, 16'd384, 16'd256, 16'd23040, 16'd512, 16'd256);
    expect_result(0, "R5 lower clamp");

    // Set point is limit minus twice margin (R2)
    cur_tag = "R2";
    fire(16'd21888, 16'd21888, 16'd256, 16'd256, 16'd23040, 16'd512, 16'd256);
    expect_result(128, "R2 set point");

    // Hold between events while inputs wander (R9)
    cur_tag = "R9";
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      put(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
          16'($urandom), 16'($urandom), 16'd0, 1'b0);
      chk(freq == 16'd128, "R9 held command", longint'(freq), 128);
    end

    // Busy strobes ignored, strobe on the done cycle accepted (R10)
    cur_tag = "R10";
    d0 = n_done_seen;
    @(negedge clk); put(16'd22000, 16'd21900, 16'd100, 16'd50, 16'd23040, 16'd256, 16'd256, 1'b1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); put(16'd25000, 16'd25000, 16'd300, 16'd10, 16'd20000, 16'd0, 16'd50, 1'b1);
    end
    @(negedge clk);
    chk(done == 1'b1, "R10 first result", longint'(done), 1);
    put(16'd21000, 16'd21100, 16'd200, 16'd100, 16'd23040, 16'd768, 16'd200, 1'b1);
    @(negedge clk); evt = 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R10 back-to-back result", longint'(done), 1);
    @(negedge clk);
    chk(n_done_seen - d0 == 2, "R10 done count", longint'(n_done_seen - d0), 2);

    // Varied events with random spacing and values (R4, R8)
    cur_tag = "R4";
    for (int i = 0; i < 60; i++) begin
      logic [DW-1:0] g;
      g = (i % 7 == 0) ? 16'hFF00 : 16'($urandom_range(0, 320));
      @(negedge clk);
      put(16'($urandom_range(15360, 25600)), 16'($urandom_range(15360, 25600)),
          16'($urandom_range(0, 400)), 16'($urandom_range(0, 400)),
          16'($urandom_range(20480, 25600)), 16'($urandom_range(0, 1024)), g, 1'b1);
      @(negedge clk); evt = 1'b0;
      repeat ($urandom_range(0, 6)) @(negedge clk);
    end
    repeat (8) @(negedge clk);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule